// File: doc/BRIEF.md
# Usage-Tagged Memory with Trap on Flagged Access

This block is a small word memory in which every word carries three usage tags, one per way the word can be used: as an instruction, as a data operand, or as an indirect-address pointer. Each access states its usage class. If the addressed word has the tag for that class set, the block raises a one-cycle trap pulse. It also records the address and the class that fired, so that trap software can learn how the word was used. Accesses that hit no set tag are served at full speed. A tagged access is served with the same latency, and the trap pulse is simply added to it.

Tags are loaded through a separate programming port that never touches the data words. Normal data writes never touch the tags. The cause record is sticky. It keeps the first trap until software acknowledges it, and later traps still pulse in the meantime. Typical uses are catching self-modifying code, stray data accesses to code regions, or pointer use of a marked word, all while the program runs at full speed.

Top module: `tag_trap_mem`

## Requirements
- R1: While reset is asserted and after it is released, trap_pulse, rd_valid and cause_valid are low, and every tag bit of every word is clear.
- R2: A read access (acc_valid=1, acc_we=0) returns the stored word on rd_data with rd_valid=1 one clock after the access is sampled. A write access (acc_we=1) stores acc_wdata. An access to a word with no matching tag never raises trap_pulse.
- R3: Usage class codes are 0 for instruction, 1 for data and 2 for indirect address. Tag bit k belongs to class k. An access of class k to a word whose tag bit k is set raises trap_pulse for exactly one clock, in the same cycle that the read data of that access is returned.
- R4: A trapping access still completes normally: its read data arrives with the usual one-cycle latency, and its write is stored.
- R5: Tag bits of classes other than the access class never cause a trap.
- R6: When a trap is recorded, cause_addr holds the trapping address and cause_mask is one-hot with bit k set for the firing class k. cause_valid rises in the same cycle as trap_pulse.
- R7: Once cause_valid is high, later traps still pulse trap_pulse but do not change cause_addr or cause_mask until the record is acknowledged.
- R8: A cause_ack clears cause_valid at the next clock. If a trap fires in that same cycle, the new trap is recorded instead and cause_valid stays high.
- R9: A tag write changes no data word, and a data write changes no tag bit.
- R10: Class code 3 never raises a trap. A read with that code is still served.
- R11: When a tag write and an access hit the same word in the same cycle, the access is checked against the old tags. The new tags take effect from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_class | input | 2 | Usage class: 0 instruction, 1 data, 2 indirect, 3 none |
| acc_addr | input | ADDR_W | Word address of the access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | DATA_W | Read data |
| tag_we | input | 1 | Tag programming write strobe |
| tag_addr | input | ADDR_W | Word whose tags are written |
| tag_wdata | input | 3 | New tag bits, bit k for class k |
| trap_pulse | output | 1 | One-cycle trap for a flagged access |
| cause_valid | output | 1 | Cause record holds an unacknowledged trap |
| cause_addr | output | ADDR_W | Address of the recorded trap |
| cause_mask | output | 3 | One-hot class that fired |
| cause_ack | input | 1 | Software acknowledge, clears the record |

## Verification
Every result of an access is due exactly one clock after the edge that samples it. This covers read data, rd_valid, trap_pulse and the cause record, and a tag write or an acknowledge likewise takes effect at that one edge. The bench drives each stimulus on the falling edge, waits for the next rising edge, and samples a moment after it, so that each check reads the value for that one access. It removes the stimulus before the following edge so that no access is counted twice. The same-cycle cases (acknowledge together with a new trap, tag write together with an access to that word) are driven in a single cycle and checked on that one following edge.

// File: rtl/tag_trap_pkg.sv
package tag_trap_pkg;

   localparam int unsigned NUM_CLS = 3;
   localparam int unsigned CLS_W   = 2;

   typedef enum logic [CLS_W-1:0] {
      USE_INSTR = 2'd0,
      USE_DATA  = 2'd1,
      USE_INDIR = 2'd2,
      USE_NONE  = 2'd3
   } use_class_e;

   // one-hot selector of the tag bit belonging to a class; none for USE_NONE
   function automatic logic [NUM_CLS-1:0] class_sel(input logic [CLS_W-1:0] c);
      logic [NUM_CLS-1:0] s;
      s = '0;
      for (int k = 0; k < NUM_CLS; k++) begin
         if (c == CLS_W'(k)) s[k] = 1'b1;
      end
      return s;
   endfunction

endpackage

// File: rtl/tag_trap_data_ram.sv
module tag_trap_data_ram #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_we,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (acc_valid && acc_we) mem_q[acc_addr] <= acc_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= acc_valid && !acc_we;
         if (acc_valid && !acc_we) rd_data <= mem_q[acc_addr];
      end
   end

   // R2: read data only appears for a read sampled one clock earlier
   a_r2_rd_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(acc_valid && !acc_we));

endmodule

// File: rtl/tag_trap_tag_file.sv
module tag_trap_tag_file
   import tag_trap_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tag_we,
   input  logic [ADDR_W-1:0]  tag_addr,
   input  logic [NUM_CLS-1:0] tag_wdata,
   input  logic               acc_valid,
   input  logic [CLS_W-1:0]   acc_class,
   input  logic [ADDR_W-1:0]  acc_addr,
   output logic [NUM_CLS-1:0] hit_now
);
   localparam int unsigned DEPTH  = 1 << ADDR_W;
   localparam int unsigned FLAT_W = DEPTH * NUM_CLS;

   logic [FLAT_W-1:0]  tag_flat;
   logic [NUM_CLS-1:0] tag_rd;

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic [NUM_CLS-1:0] tag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   tag_q <= '0;
         else if (tag_we && tag_addr == ADDR_W'(w))    tag_q <= tag_wdata;
      end
      assign tag_flat[w*NUM_CLS +: NUM_CLS] = tag_q;
   end

   // old tags are seen by an access in the same cycle as a tag write
   assign tag_rd  = tag_flat[acc_addr*NUM_CLS +: NUM_CLS];
   assign hit_now = acc_valid ? (tag_rd & class_sel(acc_class)) : '0;

endmodule

// File: rtl/tag_trap_cause.sv
module tag_trap_cause
   import tag_trap_pkg::*;
#(
   parameter int unsigned ADDR_W       = 6,
   parameter bit          STICKY_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CLS-1:0] hit_now,
   input  logic [ADDR_W-1:0]  hit_addr,
   input  logic               cause_ack,
   output logic               trap_pulse,
   output logic               cause_valid,
   output logic [ADDR_W-1:0]  cause_addr,
   output logic [NUM_CLS-1:0] cause_mask
);
   logic hit_any;
   logic take;

   assign hit_any = |hit_now;

   if (STICKY_FIRST) begin : g_keep_first
      assign take = hit_any && (!cause_valid || cause_ack);
   end else begin : g_keep_last
      assign take = hit_any;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_pulse  <= 1'b0;
         cause_valid <= 1'b0;
         cause_addr  <= '0;
         cause_mask  <= '0;
      end else begin
         trap_pulse <= hit_any;
         if (take) begin
            cause_valid <= 1'b1;
            cause_addr  <= hit_addr;
            cause_mask  <= hit_now;
         end else if (cause_ack) begin
            cause_valid <= 1'b0;
         end
      end
   end

   // R6: a held record names exactly one class
   a_r6_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      cause_valid |-> ($countones(cause_mask) == 1));

   // R6: every trap leaves a record in the same cycle
   a_r6_trap_sets_cause: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> cause_valid);

   // R8: after an acknowledge the record is empty unless a new trap landed
   a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cause_ack |=> (trap_pulse || !cause_valid));

   if (STICKY_FIRST) begin : g_sticky_chk
      // R7: an unacknowledged record does not move
      a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (cause_valid && !cause_ack) |=>
            (cause_valid && $stable(cause_addr) && $stable(cause_mask)));
   end

endmodule

// File: rtl/tag_trap_mem.sv
module tag_trap_mem
   import tag_trap_pkg::*;
#(
   parameter int unsigned ADDR_W       = 6,
   parameter int unsigned DATA_W       = 16,
   parameter bit          STICKY_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic [1:0]         acc_class,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic               acc_we,
   input  logic [DATA_W-1:0]  acc_wdata,
   output logic               rd_valid,
   output logic [DATA_W-1:0]  rd_data,
   input  logic               tag_we,
   input  logic [ADDR_W-1:0]  tag_addr,
   input  logic [2:0]         tag_wdata,
   output logic               trap_pulse,
   output logic               cause_valid,
   output logic [ADDR_W-1:0]  cause_addr,
   output logic [2:0]         cause_mask,
   input  logic               cause_ack
);
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("tag_trap_mem: ADDR_W must lie in 1..10");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("tag_trap_mem: DATA_W must be at least 1");
   end
   if (NUM_CLS != 3) begin : g_bad_cls
      $error("tag_trap_mem: three usage classes expected");
   end

   logic [NUM_CLS-1:0] hit_now;

   tag_trap_data_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_we    (acc_we),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   tag_trap_tag_file #(.ADDR_W(ADDR_W)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .tag_we    (tag_we),
      .tag_addr  (tag_addr),
      .tag_wdata (tag_wdata),
      .acc_valid (acc_valid),
      .acc_class (acc_class),
      .acc_addr  (acc_addr),
      .hit_now   (hit_now)
   );

   tag_trap_cause #(.ADDR_W(ADDR_W), .STICKY_FIRST(STICKY_FIRST)) u_cause (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit_now     (hit_now),
      .hit_addr    (acc_addr),
      .cause_ack   (cause_ack),
      .trap_pulse  (trap_pulse),
      .cause_valid (cause_valid),
      .cause_addr  (cause_addr),
      .cause_mask  (cause_mask)
   );

   // R3: a trap is always the answer to an access one clock earlier
   a_r3_trap_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> $past(acc_valid));

   // R10: the no-class code never traps
   a_r10_none_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_class == 2'd3) |=> !trap_pulse);

endmodule

// File: tb/tag_trap_mem_tb.sv
module tag_trap_mem_tb;
   localparam int AW = 6;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0;
   logic [1:0]    acc_class = '0;
   logic [AW-1:0] acc_addr = '0;
   logic          acc_we = 1'b0;
   logic [DW-1:0] acc_wdata = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic          tag_we = 1'b0;
   logic [AW-1:0] tag_addr = '0;
   logic [2:0]    tag_wdata = '0;
   logic          trap_pulse, cause_valid;
   logic [AW-1:0] cause_addr;
   logic [2:0]    cause_mask;
   logic          cause_ack = 1'b0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   tag_trap_mem #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      acc_valid = 0; acc_we = 0; tag_we = 0; cause_ack = 0;
   endtask

   // one access; samples one clock later
   task automatic access(input logic we, input logic [1:0] cls,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      acc_valid = 1; acc_we = we; acc_class = cls; acc_addr = a; acc_wdata = d;
      @(posedge clk); #1;
      idle();
   endtask

   task automatic tagw(input logic [AW-1:0] a, input logic [2:0] t);
      @(negedge clk);
      tag_we = 1; tag_addr = a; tag_wdata = t;
      @(posedge clk); #1;
      idle();
   endtask

   task automatic ack();
      @(negedge clk);
      cause_ack = 1;
      @(posedge clk); #1;
      idle();
   endtask

   // kind: 0 tag write, 1 data write, 2 read
   // {kind[2], cls[2], addr[6], data[16], exp_trap[1], exp_rdata[16]}
   localparam int NV = 14;
   localparam logic [42:0] VEC [NV] = '{
      {2'd1, 2'd1, 6'd3, 16'h1111, 1'b0, 16'h0000},   // R2 write
      {2'd1, 2'd1, 6'd4, 16'h2222, 1'b0, 16'h0000},   // R2 write
      {2'd2, 2'd0, 6'd3, 16'h0000, 1'b0, 16'h1111},   // R2 untagged read
      {2'd0, 2'd0, 6'd3, 16'h0001, 1'b0, 16'h0000},   // tag instr on word 3
      {2'd2, 2'd1, 6'd3, 16'h0000, 1'b0, 16'h1111},   // R5 other class
      {2'd2, 2'd2, 6'd3, 16'h0000, 1'b0, 16'h1111},   // R5 other class
      {2'd2, 2'd0, 6'd3, 16'h0000, 1'b1, 16'h1111},   // R3 R4 trap + data
      {2'd0, 2'd0, 6'd4, 16'h0006, 1'b0, 16'h0000},   // tag data+indirect on 4
      {2'd2, 2'd1, 6'd4, 16'h0000, 1'b1, 16'h2222},   // R3 data class
      {2'd2, 2'd2, 6'd4, 16'h0000, 1'b1, 16'h2222},   // R3 indirect class
      {2'd2, 2'd0, 6'd4, 16'h0000, 1'b0, 16'h2222},   // R5
      {2'd2, 2'd1, 6'd3, 16'h0000, 1'b0, 16'h1111},   // R9 tag write kept data
      {2'd1, 2'd1, 6'd4, 16'h3333, 1'b1, 16'h0000},   // R4 trapping write
      {2'd2, 2'd0, 6'd4, 16'h0000, 1'b0, 16'h3333}    // R4 write was stored
   };

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 trap in reset", 32'(trap_pulse), 0);
      check("R1 cause in reset", 32'(cause_valid), 0);
      @(negedge clk); rst_n = 1;
      @(posedge clk); #1;
      check("R1 rd_valid after reset", 32'(rd_valid), 0);

      for (int i = 0; i < NV; i++) begin
         logic [1:0]  kind;
         logic [1:0]  cls;
         logic [5:0]  a;
         logic [15:0] d, er;
         logic        et;
         {kind, cls, a, d, et, er} = VEC[i];
         if (kind == 2'd0) tagw(AW'(a), d[2:0]);
         else access(kind == 2'd1, cls, AW'(a), DW'(d));
         check($sformatf("R3 trap vec %0d", i), 32'(trap_pulse), 32'(et));
         if (kind == 2'd2) begin
            check($sformatf("R2 rd_valid vec %0d", i), 32'(rd_valid), 1);
            check($sformatf("R2 rd_data vec %0d", i), 32'(rd_data), 32'(er));
         end
      end

      // R6 / R7: first trap (word 3, instr) still held
      check("R7 cause held valid", 32'(cause_valid), 1);
      check("R6 R7 cause addr", 32'(cause_addr), 3);
      check("R6 R7 cause mask", 32'(cause_mask), 3'b001);

      // R8 plain acknowledge
      ack();
      check("R8 ack clears", 32'(cause_valid), 0);

      // R9 data write to word 4 kept its indirect tag; R6 record
      access(0, 2'd2, 6'd4, '0);
      check("R9 tags survive data write", 32'(trap_pulse), 1);
      check("R6 cause valid with trap", 32'(cause_valid), 1);
      check("R6 cause addr", 32'(cause_addr), 4);
      check("R6 cause mask", 32'(cause_mask), 3'b100);

      // R8 ack and new trap in the same cycle
      @(negedge clk);
      cause_ack = 1; acc_valid = 1; acc_we = 0; acc_class = 2'd1; acc_addr = 6'd4;
      @(posedge clk); #1;
      idle();
      check("R8 new trap wins", 32'(cause_valid), 1);
      check("R8 new mask", 32'(cause_mask), 3'b010);

      // R10 class code 3
      access(0, 2'd3, 6'd4, '0);
      check("R10 no trap", 32'(trap_pulse), 0);
      check("R10 read served", 32'(rd_data), 16'h3333);

      // R11 same-cycle tag write and access
      ack();
      @(negedge clk);
      tag_we = 1; tag_addr = 6'd3; tag_wdata = 3'b010;
      acc_valid = 1; acc_we = 0; acc_class = 2'd1; acc_addr = 6'd3;
      @(posedge clk); #1;
      idle();
      check("R11 old tags used", 32'(trap_pulse), 0);
      access(0, 2'd1, 6'd3, '0);
      check("R11 new tags next", 32'(trap_pulse), 1);
      check("R11 cause addr", 32'(cause_addr), 3);

      // R1 reset clears tags and record
      @(negedge clk); rst_n = 0;
      @(posedge clk); #1;
      check("R1 cause cleared", 32'(cause_valid), 0);
      @(negedge clk); rst_n = 1;
      access(0, 2'd1, 6'd4, '0);
      check("R1 tags clear after reset", 32'(trap_pulse), 0);
      access(0, 2'd1, 6'd3, '0);
      check("R1 tags clear word 3", 32'(trap_pulse), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule